// File: doc/BRIEF.md
# Framed SPI Register Command Engine

This block sits on the host side of a serial link to a display controller and turns single register requests into framed SPI byte traffic. A request names an operation (register write, register read or status read), an 8-bit register offset and 16 bits of write data. The engine builds the byte frames, shifts them out MSB first in SPI mode 0 (clock idle low, data sampled on the rising edge), collects the bytes returned on the input line and reports completion with a one-cycle done pulse. Read results are presented as a 16-bit word.

Register writes and reads each take two frames of three bytes. The first frame selects the register and the second carries the value. Chip select is released between the two frames for a programmable gap. A status read is a single frame of four bytes. Every frame opens with a generated start byte. A per-request option complements every transmitted bit. The serial clock is divided from the system clock, and the divider is clamped so that register traffic never runs faster than a rate fixed at build time.

Configuration inputs are sampled when a request is accepted. Changes made while a request is in flight therefore do not affect it.

Top module: `spi_regcmd_engine`

## Requirements
- R1: After reset and whenever no request is in progress, `req_ready` is 1, `cs_n` is 1, `sclk` is 0 and `done` is 0.
- R2: A write (`req_op`=0) sends a select frame {start, 0x00, offset}, raises `cs_n`, then sends a value frame {start, data[15:8], data[7:0]}. Each frame is 24 bits, MSB of the first byte first.
- R3: A read (`req_op`=1) sends the same select frame, raises `cs_n`, then sends {start, 0x00, 0x00}. `rd_data` is the second received byte of that frame (high) joined with the third (low).
- R4: A status read (`req_op`=2) sends one 32-bit frame {start, 0x00, 0x00, 0x00}. `rd_data` is received byte 2 (high) joined with received byte 3 (low), counting bytes from 0.
- R5: The start byte is 0x70 | (id<<2) | (sel<<1) | dir. Here id is `cfg_id`; sel is 0 for the select frame and the status frame and 1 for value frames; dir is 1 for the read value frame and the status frame and 0 otherwise.
- R6: When `cfg_invert` is 1, every transmitted bit of every frame, start byte included, is complemented.
- R7: Each `sclk` level lasts max(`cfg_half`, MIN_HALF) system cycles. MIN_HALF = ceil(SYS_CLK_HZ / (2*REG_SCLK_MAX_HZ)), so the register clock never exceeds REG_SCLK_MAX_HZ.
- R8: Between the two frames of a write or read, `cs_n` stays high for at least 2*max(`cfg_gap`,2) `sclk` half periods times the effective half period.
- R9: A request is taken only when `req_valid` and `req_ready` are both 1. `req_valid` while busy is ignored and starts no frame.
- R10: `done` is a one-cycle pulse after the last frame ends. `req_op`=3 is reserved: it sends no frame and pulses `done` together with `error`. `error` is 0 for all other operations.
- R11: `sclk` is 0 whenever `cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 write, 1 read, 2 status, 3 reserved |
| req_addr | input | 8 | Register offset |
| req_wdata | input | 16 | Write data |
| cfg_id | input | 1 | Identifier bit placed in the start byte |
| cfg_invert | input | 1 | Complement all transmitted bits |
| cfg_half | input | DIVW | Requested sclk half period in system cycles |
| cfg_gap | input | GAPW | Requested chip-select gap in sclk periods |
| req_ready | output | 1 | Engine idle, request can be taken |
| rd_data | output | 16 | Result of the last read or status request |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Reserved operation, valid with done |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the engine with SYS_CLK_HZ = 16 MHz and REG_SCLK_MAX_HZ = 4 MHz, giving MIN_HALF = 2, with DIVW = 4 and GAPW = 3. Requested half periods are drawn from 0 to 9, so both the clamp to the rate cap and the unclamped divider are exercised. Gap requests are drawn from 0 to 5, so both the two-period floor and longer programmed gaps occur. The short frame durations allow dozens of mixed requests, with both identifier values and the inversion option, to run in a short bench.

// File: rtl/spi_regcmd_pkg.sv
package spi_regcmd_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_READ   = 2'd1,
        OP_STATUS = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        FR_SELECT = 2'd0,
        FR_WVALUE = 2'd1,
        FR_RVALUE = 2'd2,
        FR_STATUS = 2'd3
    } frame_e;

    localparam int WORD_BITS  = 8;
    localparam int FRAME_MAX  = 4;
    localparam int FRAME_BITS = WORD_BITS * FRAME_MAX;
    localparam int GAP_FLOOR  = 2;

    function automatic logic [7:0] lead_byte(input logic id, input logic sel, input logic dir);
        return 8'h70 | {5'b00000, id, sel, dir};
    endfunction

    function automatic int min_half_cycles(input int sys_hz, input int max_hz);
        return (sys_hz + 2 * max_hz - 1) / (2 * max_hz);
    endfunction

endpackage

// File: rtl/spi_regcmd_framer.sv
module spi_regcmd_framer
    import spi_regcmd_pkg::*;
(
    input  frame_e                kind,
    input  logic                  id,
    input  logic                  invert,
    input  logic [7:0]            addr,
    input  logic [15:0]           wdata,
    output logic [FRAME_BITS-1:0] frame,
    output logic [2:0]            nbytes
);
    logic [FRAME_BITS-1:0] raw;

    always_comb begin
        unique case (kind)
            FR_SELECT: begin
                raw    = {lead_byte(id, 1'b0, 1'b0), 8'h00, addr, 8'h00};
                nbytes = 3'd3;
            end
            FR_WVALUE: begin
                raw    = {lead_byte(id, 1'b1, 1'b0), wdata[15:8], wdata[7:0], 8'h00};
                nbytes = 3'd3;
            end
            FR_RVALUE: begin
                raw    = {lead_byte(id, 1'b1, 1'b1), 8'h00, 8'h00, 8'h00};
                nbytes = 3'd3;
            end
            default: begin
                raw    = {lead_byte(id, 1'b0, 1'b1), 8'h00, 8'h00, 8'h00};
                nbytes = 3'd4;
            end
        endcase
        frame = invert ? ~raw : raw;
    end
endmodule

// File: rtl/spi_regcmd_clkgen.sv
module spi_regcmd_clkgen #(
    parameter int DIVW     = 4,
    parameter int MIN_HALF = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] half_req,
    output logic            tick
);
    localparam logic [DIVW-1:0] FLOOR = DIVW'(MIN_HALF);

    typedef struct packed {
        logic [DIVW-1:0] cnt;
    } clk_state_t;

    clk_state_t      q, d;
    logic [DIVW-1:0] eff_half;

    generate
        if (MIN_HALF <= 1) begin : g_noclamp
            assign eff_half = (half_req == '0) ? DIVW'(1) : half_req;
        end else begin : g_clamp
            assign eff_half = (half_req < FLOOR) ? FLOOR : half_req;
        end
    endgenerate

    always_comb begin
        d    = q;
        tick = 1'b0;
        if (!run) begin
            d.cnt = '0;
        end else if (q.cnt == eff_half - DIVW'(1)) begin
            tick  = 1'b1;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + DIVW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/spi_regcmd_shifter.sv
module spi_regcmd_shifter
    import spi_regcmd_pkg::*;
#(
    parameter int FBITS = FRAME_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [FBITS-1:0] frame,
    input  logic [2:0]       nbytes,
    input  logic             tick,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             active,
    output logic             fin,
    output logic [FBITS-1:0] rx
);
    localparam int CNTW = $clog2(FBITS + 1);

    typedef struct packed {
        logic             active;
        logic             sclk;
        logic             fin;
        logic [CNTW-1:0]  bit_idx;
        logic [CNTW-1:0]  last;
        logic [FBITS-1:0] tx;
        logic [FBITS-1:0] rx;
    } sh_state_t;

    sh_state_t q, d;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        if (start) begin
            d.active  = 1'b1;
            d.sclk    = 1'b0;
            d.bit_idx = '0;
            d.last    = CNTW'({nbytes, 3'b000}) - CNTW'(1);
            d.tx      = frame;
            d.rx      = '0;
        end else if (q.active && tick) begin
            if (!q.sclk) begin
                d.sclk = 1'b1;
                d.rx   = {q.rx[FBITS-2:0], miso};
            end else begin
                d.sclk = 1'b0;
                if (q.bit_idx == q.last) begin
                    d.active = 1'b0;
                    d.fin    = 1'b1;
                end else begin
                    d.bit_idx = q.bit_idx + CNTW'(1);
                    d.tx      = {q.tx[FBITS-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk   = q.sclk;
    assign mosi   = q.active & q.tx[FBITS-1];
    assign active = q.active;
    assign fin    = q.fin;
    assign rx     = q.rx;
endmodule

// File: rtl/spi_regcmd_engine.sv
module spi_regcmd_engine
    import spi_regcmd_pkg::*;
#(
    parameter int SYS_CLK_HZ      = 50_000_000,
    parameter int REG_SCLK_MAX_HZ = 4_000_000,
    parameter int DIVW            = 4,
    parameter int GAPW            = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic [7:0]      req_addr,
    input  logic [15:0]     req_wdata,
    input  logic            cfg_id,
    input  logic            cfg_invert,
    input  logic [DIVW-1:0] cfg_half,
    input  logic [GAPW-1:0] cfg_gap,
    output logic            req_ready,
    output logic [15:0]     rd_data,
    output logic            done,
    output logic            error,
    output logic            sclk,
    output logic            mosi,
    output logic            cs_n,
    input  logic            miso
);
    localparam int MIN_HALF = min_half_cycles(SYS_CLK_HZ, REG_SCLK_MAX_HZ);
    localparam int GCW      = GAPW + 1;
    localparam logic [GAPW-1:0] GFLOOR = GAPW'(GAP_FLOOR);

    typedef enum logic [2:0] {
        S_IDLE, S_F1_GO, S_F1_RUN, S_GAP, S_F2_GO, S_F2_RUN, S_FIN
    } seq_e;

    typedef struct packed {
        seq_e            st;
        op_e             op;
        logic [7:0]      addr;
        logic [15:0]     wdata;
        logic            id;
        logic            inv;
        logic [DIVW-1:0] half;
        logic [GAPW-1:0] gap;
        logic [GCW-1:0]  gcnt;
        logic [15:0]     rdata;
        logic            err;
    } eng_state_t;

    eng_state_t q, d;

    logic                  tick, sh_active, sh_fin, sh_start, run;
    logic [FRAME_BITS-1:0] frame, rx;
    logic [2:0]            nbytes;
    frame_e                kind;
    logic [GAPW-1:0]       eff_gap;
    logic [GCW-1:0]        gap_ticks;

    assign eff_gap   = (q.gap < GFLOOR) ? GFLOOR : q.gap;
    assign gap_ticks = {eff_gap, 1'b0};
    assign sh_start  = (q.st == S_F1_GO) || (q.st == S_F2_GO);
    assign run       = sh_active || (q.st == S_GAP);

    always_comb begin
        if (q.st == S_F1_GO || q.st == S_F1_RUN)
            kind = (q.op == OP_STATUS) ? FR_STATUS : FR_SELECT;
        else
            kind = (q.op == OP_READ) ? FR_RVALUE : FR_WVALUE;
    end

    spi_regcmd_framer u_framer (
        .kind   (kind),
        .id     (q.id),
        .invert (q.inv),
        .addr   (q.addr),
        .wdata  (q.wdata),
        .frame  (frame),
        .nbytes (nbytes)
    );

    spi_regcmd_clkgen #(.DIVW(DIVW), .MIN_HALF(MIN_HALF)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_req (q.half),
        .tick     (tick)
    );

    spi_regcmd_shifter #(.FBITS(FRAME_BITS)) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sh_start),
        .frame  (frame),
        .nbytes (nbytes),
        .tick   (tick),
        .miso   (miso),
        .sclk   (sclk),
        .mosi   (mosi),
        .active (sh_active),
        .fin    (sh_fin),
        .rx     (rx)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.op    = op_e'(req_op);
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.id    = cfg_id;
                    d.inv   = cfg_invert;
                    d.half  = cfg_half;
                    d.gap   = cfg_gap;
                    d.err   = (op_e'(req_op) == OP_RSVD);
                    d.st    = (op_e'(req_op) == OP_RSVD) ? S_FIN : S_F1_GO;
                end
            end
            S_F1_GO: d.st = S_F1_RUN;
            S_F1_RUN: begin
                if (sh_fin) begin
                    d.gcnt = '0;
                    if (q.op == OP_STATUS) begin
                        d.rdata = rx[15:0];
                        d.st    = S_FIN;
                    end else begin
                        d.st = S_GAP;
                    end
                end
            end
            S_GAP: begin
                if (tick) begin
                    if (q.gcnt == gap_ticks - GCW'(1)) d.st = S_F2_GO;
                    else                               d.gcnt = q.gcnt + GCW'(1);
                end
            end
            S_F2_GO: d.st = S_F2_RUN;
            S_F2_RUN: begin
                if (sh_fin) begin
                    if (q.op == OP_READ) d.rdata = rx[15:0];
                    d.st = S_FIN;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == S_IDLE);
    assign done      = (q.st == S_FIN);
    assign error     = (q.st == S_FIN) && q.err;
    assign rd_data   = q.rdata;
    assign cs_n      = !(q.st == S_F1_GO || q.st == S_F1_RUN ||
                         q.st == S_F2_GO || q.st == S_F2_RUN);
endmodule

// File: rtl/spi_regcmd_checker.sv
module spi_regcmd_checker
    import spi_regcmd_pkg::*;
#(
    parameter int SYS_CLK_HZ      = 50_000_000,
    parameter int REG_SCLK_MAX_HZ = 4_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic error,
    input logic sclk,
    input logic cs_n
);
    localparam int MIN_HALF = min_half_cycles(SYS_CLK_HZ, REG_SCLK_MAX_HZ);

    logic        sclk_prev;
    logic [15:0] hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            hold      <= '1;
        end else begin
            sclk_prev <= sclk;
            if (sclk != sclk_prev)  hold <= 16'd1;
            else if (hold != '1)    hold <= hold + 16'd1;
        end
    end

    assert_idle_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && !done));

    assert_sclk_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_half_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != sclk_prev) |-> (hold >= 16'(MIN_HALF)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_error_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    assert_busy_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_ready_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    assert_gap_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);
endmodule

bind spi_regcmd_engine spi_regcmd_checker #(
    .SYS_CLK_HZ      (SYS_CLK_HZ),
    .REG_SCLK_MAX_HZ (REG_SCLK_MAX_HZ)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .error     (error),
    .sclk      (sclk),
    .cs_n      (cs_n)
);

// File: tb/tb_spi_regcmd_engine.sv
module tb_spi_regcmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int SYS_HZ     = 16_000_000;
    localparam int MAX_HZ     = 4_000_000;
    localparam int DIVW       = 4;
    localparam int GAPW       = 3;
    localparam int MIN_HALF   = (SYS_HZ + 2 * MAX_HZ - 1) / (2 * MAX_HZ);

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [7:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic cfg_id = 1'b1, cfg_invert = 1'b0;
    logic [DIVW-1:0] cfg_half = '0;
    logic [GAPW-1:0] cfg_gap = '0;
    logic req_ready, done, error, sclk, mosi, cs_n;
    logic miso = 1'b0;
    logic [15:0] rd_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_regcmd_engine #(
        .SYS_CLK_HZ(SYS_HZ), .REG_SCLK_MAX_HZ(MAX_HZ), .DIVW(DIVW), .GAPW(GAPW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_id(cfg_id),
        .cfg_invert(cfg_invert), .cfg_half(cfg_half), .cfg_gap(cfg_gap),
        .req_ready(req_ready), .rd_data(rd_data), .done(done), .error(error),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso)
    );

    int vectors = 0, errors = 0;
    bit finished = 0;
    int cyc = 0;
    always @(posedge clk) cyc++;

    // SPI slave model
    logic [31:0] slave_resp = '0;
    logic [31:0] shacc = '0;
    logic [31:0] facc [0:3];
    int fbits [0:3];
    int nfr = 0, sbit = 0;
    int last_rise = 0, have_rise = 0, exp_period = 0, per_err = 0;
    int t_up = 0, exp_gap = 0, gap_bad = 0;

    always @(negedge cs_n) begin
        if (nfr == 1 && (cyc - t_up) < exp_gap) gap_bad++;
        sbit = 0; shacc = '0; have_rise = 0;
        miso = slave_resp[31];
    end
    always @(posedge cs_n) begin
        if (nfr < 4) begin facc[nfr] = shacc; fbits[nfr] = sbit; end
        nfr++;
        t_up = cyc;
    end
    always @(posedge sclk) if (!cs_n) begin
        shacc = {shacc[30:0], mosi};
        sbit++;
        if (have_rise != 0 && (cyc - last_rise) != exp_period) per_err++;
        last_rise = cyc; have_rise = 1;
    end
    always @(negedge sclk) if (!cs_n) miso = (sbit < 32) ? slave_resp[31 - sbit] : 1'b0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] sb(input logic id, input logic sel, input logic dir);
        return 8'h70 | {5'd0, id, sel, dir};
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic run_txn(input logic [1:0] op, input logic [7:0] addr, input logic [15:0] wd,
                           input logic id, input logic inv, input int half, input int gap,
                           input logic [31:0] resp, input bit intrude);
        logic [23:0] e_sel, e_val;
        logic [31:0] e_st, mask;
        logic got_err;
        logic [15:0] got_rd;
        int eh, waited;
        bit seen;
        eh = imax(half, MIN_HALF);
        mask = inv ? 32'hFFFF_FFFF : 32'h0;
        e_sel = {sb(id, 1'b0, 1'b0), 8'h00, addr} ^ mask[23:0];
        e_val = (op == 2'd1) ? ({sb(id, 1'b1, 1'b1), 16'h0000} ^ mask[23:0])
                             : ({sb(id, 1'b1, 1'b0), wd} ^ mask[23:0]);
        e_st  = {sb(id, 1'b0, 1'b1), 24'h0} ^ mask;
        @(negedge clk);
        cfg_id = id; cfg_invert = inv; cfg_half = DIVW'(half); cfg_gap = GAPW'(gap);
        slave_resp = resp; nfr = 0; per_err = 0; gap_bad = 0;
        exp_period = 2 * eh; exp_gap = 2 * imax(gap, 2) * eh;
        chk("R9 ready when idle", {31'd0, req_ready}, 32'd1);
        req_op = op; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        seen = 0; waited = 0; got_err = 0; got_rd = '0;
        while (!seen && waited < 6000) begin
            if (intrude && waited == 10) begin
                chk("R9 not ready while busy", {31'd0, req_ready}, 32'd0);
                req_op = 2'd2; req_valid = 1'b1;
            end
            if (intrude && waited == 11) req_valid = 1'b0;
            if (done) begin seen = 1; got_err = error; got_rd = rd_data; end
            else begin @(negedge clk); waited++; end
        end
        chk("R10 done seen", {31'd0, seen}, 32'd1);
        @(negedge clk);
        chk("R10 done single cycle", {31'd0, done}, 32'd0);
        if (op == 2'd3) begin
            chk("R10 reserved op error", {31'd0, got_err}, 32'd1);
            chk("R10 reserved op no frame", nfr, 0);
        end else begin
            chk("R10 no error", {31'd0, got_err}, 32'd0);
            chk("R7 sclk period", per_err, 0);
            if (op == 2'd2) begin
                chk("R4 status frame count", nfr, 1);
                chk("R4 status frame bits", fbits[0], 32);
                chk("R4 R5 R6 status frame", facc[0], e_st);
                chk("R4 status data", {16'd0, got_rd}, {16'd0, resp[15:0]});
            end else begin
                chk("R2 frame count", nfr, 2);
                chk("R2 select frame bits", fbits[0], 24);
                chk("R2 value frame bits", fbits[1], 24);
                chk("R2 R5 R6 select frame", facc[0][23:0], {8'd0, e_sel});
                chk("R8 chip select gap", gap_bad, 0);
                if (op == 2'd1) begin
                    chk("R3 R5 R6 read value frame", facc[1][23:0], {8'd0, e_val});
                    chk("R3 read data", {16'd0, got_rd}, {16'd0, resp[23:8]});
                end else begin
                    chk("R2 R5 R6 write value frame", facc[1][23:0], {8'd0, e_val});
                end
            end
        end
        repeat (40) @(negedge clk);
        if (intrude) begin
            chk("R9 busy request ignored", nfr, (op == 2'd2) ? 1 : 2);
            chk("R1 idle after ignored request", {30'd0, cs_n, req_ready}, 32'd3);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", {28'd0, req_ready, cs_n, sclk, done}, 32'b1100);
        // directed corners
        run_txn(2'd0, 8'h22, 16'hA55A, 1'b1, 1'b0, 0, 0, 32'h0, 0);       // R2 rate clamp
        run_txn(2'd1, 8'h00, 16'h0000, 1'b0, 1'b0, 9, 5, 32'h12_9221_00, 0); // R3 slow clock, long gap
        run_txn(2'd2, 8'h00, 16'h0000, 1'b1, 1'b1, 3, 1, 32'hDEAD_BEEF, 0); // R4 with inversion R6
        run_txn(2'd3, 8'h10, 16'h1234, 1'b1, 1'b0, 2, 2, 32'h0, 0);       // R10 reserved
        run_txn(2'd0, 8'hFF, 16'hFFFF, 1'b0, 1'b1, 1, 0, 32'h0, 1);       // R9 busy ignore
        run_txn(2'd1, 8'h45, 16'h0, 1'b1, 1'b1, 5, 3, 32'h00_FFFF_00, 0);
        for (int i = 0; i < 40; i++) begin
            logic [1:0] op;
            op = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
            run_txn(op, 8'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                    int'($urandom % 10), int'($urandom % 6), $urandom, 0);
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule